// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the slave-side serial interface of a small NOR flash device. It oversamples the serial clock, chip select and data input with the system clock. It collects an opcode and then the address, dummy and data bytes that opcode calls for. For read-type commands it shifts the response out. When chip select is released it hands validated commit commands (page program, block erase, chip erase, status write, power-down) to a back end as a one-cycle strobe.

The block holds the write-enable latch, the busy flag, the power-down state and six user status bits. A back end that owns the array answers reads combinationally through `rd_addr`/`rd_data`. It takes page data bytes as they arrive and reports the end of a program, erase or status write with a single `wr_done` pulse.

Top module: `spi_flash_cmd_front`

## Requirements
- R1: After reset, `miso_oe` is low, no command strobe has been issued, and a status read returns 00h.
- R2: Serial input is latched on rising serial-clock edges while chip select is low, most significant bit first. Accepted opcodes are 06h, 04h, 05h, 01h, 03h, 0Bh, 02h, D8h, C7h, B9h, ABh and 90h. Any other opcode has no effect.
- R3: Opcode 06h sets the write-enable latch and 04h clears it. A status read (05h) returns bit 0 = busy, bit 1 = write-enable latch and bits 7:2 = the value from the last accepted status write. It repeats that byte until chip select rises.
- R4: A read (03h) takes three address bytes and returns `rd_data` for consecutive addresses starting there, until chip select rises. `miso` changes only after falling serial-clock edges.
- R5: A fast read (0Bh) behaves as R4 but expects one dummy byte after the address.
- R6: Opcode 90h, followed by three dummy bytes, returns MFR_ID then DEV_ID, alternating. Opcode ABh leaves power-down at once. If three dummy bytes follow it, it returns DEV_ID repeatedly.
- R7: After opcode 02h and three address bytes, each data byte pulses `pp_valid` with `pp_data`, up to PAGE_BYTES bytes per frame. Later bytes are not forwarded. The commit strobe carries code 0 and the start address.
- R8: Page program (code 0, needs at least one data byte), block erase D8h (code 1, needs three address bytes), chip erase C7h (code 2), status write 01h (code 3, first data byte on `cmd_data`) and power-down B9h (code 4) commit only if the count of rising edges at chip-select release is a nonzero multiple of 8. Otherwise they are dropped.
- R9: Codes 0 to 3 commit only while the write-enable latch is set, and they set busy. A `wr_done` pulse while busy clears both busy and the latch.
- R10: While busy, every opcode except 05h is ignored.
- R11: After a power-down commit, every opcode except ABh is ignored.
- R12: `miso_oe` is high exactly while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock, synchronous to clk |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for miso |
| rd_addr | output | 24 | Array address for read data |
| rd_data | input | 8 | Array byte at rd_addr |
| pp_valid | output | 1 | Program data byte strobe |
| pp_data | output | 8 | Program data byte |
| cmd_valid | output | 1 | Commit strobe |
| cmd_code | output | 3 | 0 program, 1 block erase, 2 chip erase, 3 status write, 4 power-down |
| cmd_addr | output | 24 | Address of the committed command |
| cmd_data | output | 8 | Status write byte |
| wr_done | input | 1 | Back end finished the running write |

## Verification
The bench builds the block with PAGE_BYTES = 4, so the page-overflow cut-off in R7 is reached with a six-byte frame instead of hundreds of bytes. Distinct MFR_ID = C2h and DEV_ID = 37h make the alternation of the ID reads visible. Three system clocks per serial half period give the edge detectors room to act, so byte and bit alignment at chip-select release can be probed with short frames.

// File: rtl/spi_flash_cmd_front.sv
module spi_flash_cmd_front #(
  parameter int         PAGE_BYTES = 256,
  parameter logic [7:0] MFR_ID     = 8'hC5,
  parameter logic [7:0] DEV_ID     = 8'h10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck,
  input  logic        cs_n,
  input  logic        mosi,
  output logic        miso,
  output logic        miso_oe,
  output logic [23:0] rd_addr,
  input  logic [7:0]  rd_data,
  output logic        pp_valid,
  output logic [7:0]  pp_data,
  output logic        cmd_valid,
  output logic [2:0]  cmd_code,
  output logic [23:0] cmd_addr,
  output logic [7:0]  cmd_data,
  input  logic        wr_done
);
  localparam int PCW = $clog2(PAGE_BYTES + 1);
  localparam logic [2:0] CMD_PROG = 3'd0, CMD_BERASE = 3'd1, CMD_CERASE = 3'd2,
                         CMD_SRW = 3'd3, CMD_PDOWN = 3'd4;

  typedef enum logic [2:0] {S_OPC, S_ADDR, S_DUMMY, S_DIN, S_DOUT, S_HOLD} st_t;

  st_t        st;
  logic       sck_q, cs_q, busy, wel, pd, armed, idsel;
  logic [6:0] sh;
  logic [2:0] bitcnt;
  logic [1:0] cnt;
  logic [7:0] op, tx, wdat;
  logic [5:0] sr_hi;
  logic [23:0] addr;
  logic [PCW-1:0] ppn;

  wire       cs_start = cs_q && !cs_n;
  wire       cs_end   = !cs_q && cs_n;
  wire       rise     = sck && !sck_q && !cs_n && !cs_q;
  wire       fall     = !sck && sck_q && !cs_n && !cs_q;
  wire [7:0] shift_in = {sh, mosi};
  wire [7:0] status   = {sr_hi, wel, busy};

  logic known, acc;
  always_comb begin
    case (shift_in)
      8'h06, 8'h04, 8'h05, 8'h01, 8'h03, 8'h0B,
      8'h02, 8'hD8, 8'hC7, 8'hB9, 8'hAB, 8'h90: known = 1'b1;
      default: known = 1'b0;
    endcase
    acc = pd ? (shift_in == 8'hAB) : busy ? (shift_in == 8'h05) : known;
  end

  logic [7:0] src, cur;
  always_comb begin
    case (op)
      8'h05:        src = status;
      8'h03, 8'h0B: src = rd_data;
      8'h90:        src = idsel ? DEV_ID : MFR_ID;
      default:      src = DEV_ID;
    endcase
    cur = (bitcnt == 3'd0) ? src : tx;
  end

  logic [2:0] code_of_op;
  always_comb
    case (op)
      8'h02:   code_of_op = CMD_PROG;
      8'hD8:   code_of_op = CMD_BERASE;
      8'hC7:   code_of_op = CMD_CERASE;
      8'h01:   code_of_op = CMD_SRW;
      default: code_of_op = CMD_PDOWN;
    endcase

  assign miso_oe = !cs_n;
  assign rd_addr = addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_HOLD; sck_q <= 1'b0; cs_q <= 1'b1; busy <= 1'b0; wel <= 1'b0;
      pd <= 1'b0; armed <= 1'b0; idsel <= 1'b0; sh <= '0; bitcnt <= '0;
      cnt <= '0; op <= '0; tx <= '0; wdat <= '0; sr_hi <= '0; addr <= '0;
      ppn <= '0; miso <= 1'b0; pp_valid <= 1'b0; pp_data <= '0;
      cmd_valid <= 1'b0; cmd_code <= '0; cmd_addr <= '0; cmd_data <= '0;
    end else begin
      sck_q     <= sck;
      cs_q      <= cs_n;
      cmd_valid <= 1'b0;
      pp_valid  <= 1'b0;
      if (wr_done && busy) begin
        busy <= 1'b0;
        wel  <= 1'b0;
      end
      if (cs_start) begin
        st <= S_OPC; bitcnt <= '0; armed <= 1'b0; cnt <= '0; ppn <= '0; idsel <= 1'b0;
      end else if (rise) begin
        sh     <= shift_in[6:0];
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7)
          case (st)
            S_OPC:
              if (!acc) st <= S_HOLD;
              else begin
                op <= shift_in;
                cnt <= '0;
                st <= S_HOLD;
                case (shift_in)
                  8'h06: wel <= 1'b1;
                  8'h04: wel <= 1'b0;
                  8'h05: st <= S_DOUT;
                  8'h01: st <= S_DIN;
                  8'h03, 8'h0B, 8'h02, 8'hD8: st <= S_ADDR;
                  8'hC7, 8'hB9: armed <= 1'b1;
                  8'h90: st <= S_DUMMY;
                  8'hAB: begin pd <= 1'b0; st <= S_DUMMY; end
                  default: ;
                endcase
              end
            S_ADDR: begin
              addr <= {addr[15:0], shift_in};
              cnt  <= cnt + 2'd1;
              if (cnt == 2'd2)
                case (op)
                  8'h03:   st <= S_DOUT;
                  8'h0B:   begin st <= S_DUMMY; cnt <= '0; end
                  8'h02:   st <= S_DIN;
                  default: begin armed <= 1'b1; st <= S_HOLD; end
                endcase
            end
            S_DUMMY: begin
              cnt <= cnt + 2'd1;
              if (cnt == ((op == 8'h0B) ? 2'd0 : 2'd2)) st <= S_DOUT;
            end
            S_DIN: begin
              armed <= 1'b1;
              if (op == 8'h01) begin
                wdat <= shift_in;
                st   <= S_HOLD;
              end else if (ppn < PCW'(PAGE_BYTES)) begin
                pp_valid <= 1'b1;
                pp_data  <= shift_in;
                ppn      <= ppn + 1'b1;
              end
            end
            default: ;
          endcase
      end else if (fall && st == S_DOUT) begin
        miso <= cur[~bitcnt];
        if (bitcnt == 3'd0) begin
          tx <= src;
          if (op == 8'h03 || op == 8'h0B) addr <= addr + 24'd1;
          if (op == 8'h90) idsel <= !idsel;
        end
      end else if (cs_end) begin
        st <= S_HOLD;
        if (armed && bitcnt == 3'd0 && (op == 8'hB9 || wel)) begin
          cmd_valid <= 1'b1;
          cmd_code  <= code_of_op;
          cmd_addr  <= addr;
          cmd_data  <= wdat;
          if (op == 8'hB9) pd <= 1'b1;
          else busy <= 1'b1;
          if (op == 8'h01) sr_hi <= wdat[7:2];
        end
      end
    end

  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cmd_valid && cmd_code != CMD_PDOWN);
  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(wr_done));
  // R9
  wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code != CMD_PDOWN |-> $past(wel));
  // R11
  pd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd) |-> cmd_valid && cmd_code == CMD_PDOWN);
  // R10
  pp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pp_valid |-> !busy);
  // R8
  cmd_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cs_n);
endmodule

// File: tb/tb_spi_flash_cmd_front.sv
module tb_spi_flash_cmd_front;
  localparam int H = 3;
  localparam logic [7:0] MFR = 8'hC2, DEV = 8'h37;

  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, mosi = 0, wr_done = 0;
  logic miso, miso_oe, pp_valid, cmd_valid;
  logic [23:0] rd_addr, cmd_addr;
  logic [7:0]  rd_data, pp_data, cmd_data;
  logic [2:0]  cmd_code;
  int total = 0, bad = 0, ncmd = 0, npp = 0;
  logic [2:0]  last_code;
  logic [23:0] last_addr;
  logic [7:0]  last_data;
  logic [7:0]  ppbuf [0:15];

  always #2 clk = ~clk;

  function automatic logic [7:0] memf(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
  endfunction
  assign rd_data = memf(rd_addr);

  spi_flash_cmd_front #(.PAGE_BYTES(4), .MFR_ID(MFR), .DEV_ID(DEV)) dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .miso_oe(miso_oe), .rd_addr(rd_addr), .rd_data(rd_data), .pp_valid(pp_valid),
    .pp_data(pp_data), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wr_done(wr_done));

  always @(negedge clk) begin
    if (cmd_valid) begin
      ncmd++; last_code = cmd_code; last_addr = cmd_addr; last_data = cmd_data;
    end
    if (pp_valid) begin
      if (npp < 16) ppbuf[npp] = pp_data;
      npp++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bits(input logic [7:0] b, input int n, output logic [7:0] r);
    r = 0;
    for (int i = 0; i < n; i++) begin
      mosi = b[7-i];
      repeat (H) @(negedge clk);
      r = {r[6:0], miso};
      sck = 1;
      repeat (H) @(negedge clk);
      sck = 0;
    end
  endtask

  task automatic xb(input logic [7:0] b);
    logic [7:0] r;
    bits(b, 8, r);
  endtask

  task automatic begin_frame;
    cs_n = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic end_frame;
    repeat (2) @(negedge clk);
    cs_n = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic one(input logic [7:0] b);
    begin_frame; xb(b); end_frame;
  endtask

  task automatic rdsr(output logic [7:0] s);
    begin_frame; xb(8'h05); bits(8'h00, 8, s); end_frame;
  endtask

  task automatic pulse_done;
    wr_done = 1; @(negedge clk); wr_done = 0; @(negedge clk);
  endtask

  task automatic do_read(input logic fast, input logic [23:0] a, input int len, input string req);
    logic [7:0] r;
    begin_frame;
    xb(fast ? 8'h0B : 8'h03);
    xb(a[23:16]); xb(a[15:8]); xb(a[7:0]);
    if (fast) xb(8'h00);
    for (int k = 0; k < len; k++) begin
      bits(8'h00, 8, r);
      check(req, r, memf(a + 24'(k)));
    end
    end_frame;
  endtask

  task automatic do_pp(input logic [23:0] a, input int len, input logic [7:0] seed);
    begin_frame;
    xb(8'h02); xb(a[23:16]); xb(a[15:8]); xb(a[7:0]);
    for (int k = 0; k < len; k++) xb(seed + 8'(k * 29));
    end_frame;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] s, r;
    int c0, p0, len;
    logic [23:0] a;
    s = 8'($urandom(32'h1F2E3D4C));
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 oe", miso_oe, 0);
    check("R1 cmd", ncmd, 0);
    rdsr(s); check("R1 status", s, 8'h00);
    // R12 output enable follows chip select
    begin_frame; check("R12 oe low cs", miso_oe, 1); end_frame;
    check("R12 oe high cs", miso_oe, 0);
    // R3 latch control
    one(8'h06); rdsr(s); check("R3 wren", s, 8'h02);
    one(8'h04); rdsr(s); check("R3 wrdi", s, 8'h00);
    // R2 unknown opcode ignored
    one(8'h06); one(8'h9F); rdsr(s); check("R2 unknown opc", s, 8'h02);
    one(8'h04);
    // R4 / R5 reads
    do_read(0, 24'h012345, 5, "R4 read");
    do_read(1, 24'hFFFFFE, 4, "R5 fast read wrap");
    // R6 ID read
    begin_frame; xb(8'h90); xb(0); xb(0); xb(0);
    for (int k = 0; k < 4; k++) begin
      bits(8'h00, 8, r); check("R6 id", r, (k % 2) ? DEV : MFR);
    end
    end_frame;
    // R9 program without write enable rejected
    c0 = ncmd; p0 = npp;
    do_pp(24'h000100, 2, 8'h11);
    check("R9 no wel", ncmd, c0);
    // R7 program
    one(8'h06);
    npp = 0; c0 = ncmd;
    do_pp(24'h00ABCD, 3, 8'h40);
    check("R7 commit", ncmd, c0 + 1);
    check("R7 code", last_code, 0);
    check("R7 addr", last_addr, 24'h00ABCD);
    check("R7 count", npp, 3);
    for (int k = 0; k < 3; k++) check("R7 byte", ppbuf[k], 8'h40 + 8'(k * 29));
    rdsr(s); check("R9 busy", s, 8'h03);
    // R10 while busy
    c0 = ncmd;
    begin_frame; xb(8'hD8); xb(0); xb(0); xb(0); end_frame;
    one(8'hC7);
    check("R10 ignored", ncmd, c0);
    one(8'h04); rdsr(s); check("R10 wrdi ignored", s, 8'h03);
    pulse_done;
    rdsr(s); check("R9 done", s, 8'h00);
    // R7 overflow beyond page
    one(8'h06); npp = 0;
    do_pp(24'h000200, 6, 8'h01);
    check("R7 page limit", npp, 4);
    pulse_done;
    // R8 byte boundary
    one(8'h06); c0 = ncmd;
    begin_frame; xb(8'hD8); xb(8'h01); xb(8'h02); xb(8'h03); bits(8'hFF, 3, r); end_frame;
    check("R8 misaligned", ncmd, c0);
    rdsr(s); check("R8 wel kept", s, 8'h02);
    begin_frame; xb(8'hD8); xb(8'h01); xb(8'h02); end_frame;
    check("R8 short addr", ncmd, c0);
    one(8'hC7);
    check("R8 aligned", ncmd, c0 + 1);
    check("R8 code", last_code, 2);
    pulse_done;
    // R3 status write
    one(8'h06);
    begin_frame; xb(8'h01); xb(8'hFC); end_frame;
    check("R3 srw code", last_code, 3);
    check("R3 srw data", last_data, 8'hFC);
    pulse_done;
    rdsr(s); check("R3 sr bits", s, 8'hFC);
    one(8'h06);
    begin_frame; xb(8'h01); xb(8'h00); end_frame;
    pulse_done;
    // R11 power-down
    c0 = ncmd;
    one(8'hB9);
    check("R11 pd commit", ncmd, c0 + 1);
    check("R11 pd code", last_code, 4);
    one(8'h06); one(8'hC7);
    check("R11 ignored", ncmd, c0 + 1);
    // R6 release with ID
    begin_frame; xb(8'hAB); xb(0); xb(0); xb(0);
    for (int k = 0; k < 2; k++) begin
      bits(8'h00, 8, r); check("R6 release id", r, DEV);
    end
    end_frame;
    rdsr(s); check("R11 wel not set", s, 8'h00);
    // random reads and programs
    for (int it = 0; it < 24; it++) begin
      a = 24'($urandom);
      len = 1 + int'($urandom % 5);
      if (it % 3 == 2) begin
        one(8'h06); npp = 0; c0 = ncmd; s = 8'($urandom);
        do_pp(a, len, s);
        check("R7 rand commit", ncmd, c0 + 1);
        check("R7 rand addr", last_addr, a);
        check("R7 rand count", npp, (len > 4) ? 4 : len);
        check("R7 rand first", ppbuf[0], s);
        pulse_done;
      end else
        do_read(it[0], a, len, "R4 rand read");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule